// File: doc/BRIEF.md
# Addressed Serial Octal Code Register Bank

This block is the digital front end of an eight-channel converter. A three-wire serial port (serial clock, serial data, load strobe) feeds a twelve-stage shift register. Each rising serial clock edge moves one bit in. After a full word, raising the load strobe copies the low eight bits of the word into one of eight holding registers. The top four bits of the word pick that register. The eight holding registers drive the block's eight output codes.

The last shift stage drives a serial output, so several parts can share one stream and one load line. An active-low preset input forces every holding register to midscale (80h) at once, without waiting for a clock. The serial pins are sampled in the system clock domain: the serial clock and the load strobe each pass through a two-flop synchroniser, and the serial clock is then edge-detected. A rising serial clock edge that arrives while the load strobe is high sets a sticky error flag.

Top module: `serdac_bank`

## Requirements
- R1: After system reset all eight codes read 80h, `sdout` is 0 and `proto_err` is 0.
- R2: Each rising edge of `sclk` shifts `sdin` into a 12-bit register. The first four bits of a word are the address, MSB first. The last eight bits are the data, MSB first.
- R3: Address 0001 writes channel 0 (`codes[7:0]`). Address n, for n from 1 to 8, writes channel n-1 (`codes[8n-1:8n-8]`).
- R4: A load with address 0000, or with any address from 1001 to 1111, leaves all eight codes unchanged.
- R5: A load changes only the addressed channel. The other seven channels keep their values.
- R6: `sdout` carries the `sdin` stream delayed by 12 serial clock edges. Before 12 edges have occurred since reset, it carries 0.
- R7: While `preset_n` is low, all eight codes read 80h. This takes effect without a system clock edge and overrides a load that is active at the same time.
- R8: If `sload` is still high when `preset_n` returns high, the addressed channel takes the data held in the shift register.
- R9: While there is no serial clock edge and the load strobe is low, nothing changes: neither the codes nor `sdout`, even when `sdin` toggles.
- R10: A rising `sclk` edge seen while `sload` is high sets `proto_err`, which stays set until reset. The shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| sclk | input | 1 | Serial clock; a rising edge shifts one bit in |
| sdin | input | 1 | Serial data in |
| sload | input | 1 | Load strobe, active high |
| preset_n | input | 1 | Active-low asynchronous midscale preset |
| sdout | output | 1 | Last shift stage, for daisy-chaining |
| codes | output | 64 | Eight 8-bit channel codes; channel k in bits [8k+7:8k] |
| proto_err | output | 1 | Sticky flag: serial clock rose during a load |

## Verification
Words are sent to every valid address, each with a distinct data pattern. Comparing the whole 64-bit code vector after each word catches a wrong bit order, a wrong address decode or a write that lands on a neighbouring channel. The no-operation addresses 0000, 1001 and 1111 are also sent with non-midscale data; these show whether the decoder ignores them. The serial output is compared against the input history after every edge. This shows whether the delay is exactly twelve edges. Further sequences cover a preset asserted during an active load, a preset released while the load is still high, and a serial clock edge inside a load pulse. Together they separate the preset override, the release race and the sticky error.

// File: rtl/serdac_bank.sv
module serdac_bank #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              sload,
  input  logic              preset_n,
  output logic              sdout,
  output logic [NCH*DW-1:0] codes,
  output logic              proto_err
);
  localparam int SW = AW + DW;
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [2:0]    sclk_p;
  logic [1:0]    sdin_p, load_p;
  logic [SW-1:0] shreg;
  logic          sclk_rise, load_s, hold_clr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      sdin_p <= '0;
      load_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      sdin_p <= {sdin_p[0], sdin};
      load_p <= {load_p[0], sload};
    end
  end

  assign sclk_rise  = sclk_p[1] & ~sclk_p[2];
  assign load_s     = load_p[1];
  assign addr       = shreg[SW-1:DW];
  assign data       = shreg[DW-1:0];
  assign sdout      = shreg[SW-1];
  assign hold_clr_n = rst_n & preset_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      proto_err <= 1'b0;
    end else begin
      if (sclk_rise) shreg <= {shreg[SW-2:0], sdin_p[1]};
      if (sclk_rise && load_s) proto_err <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] hold;
    always_ff @(posedge clk or negedge hold_clr_n) begin
      if (!hold_clr_n) hold <= MID;
      else if (load_s && addr == AW'(g + 1)) hold <= data;
    end
    assign codes[g*DW +: DW] = hold;
  end
endmodule

// File: rtl/serdac_bank_chk.sv
module serdac_bank_chk #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              preset_n,
  input logic              load_s,
  input logic              sclk_rise,
  input logic [AW+DW-1:0]  shreg,
  input logic [NCH*DW-1:0] codes,
  input logic              sdout,
  input logic              proto_err
);
  localparam int SW = AW + DW;
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};
  logic noop;
  assign noop = (shreg[SW-1:DW] == '0) || (shreg[SW-1:DW] > AW'(NCH));

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shreg[SW-1:1] == $past(shreg[SW-2:0]));
  assert_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_s && preset_n && noop |=> !preset_n || $stable(codes));
  assert_sdout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sdout == $past(shreg[SW-2]));
  assert_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |-> codes == {NCH{MID}});
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_s |=> !preset_n || $stable(codes));
  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise && load_s |=> proto_err);
  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind serdac_bank serdac_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .load_s(load_s),
  .sclk_rise(sclk_rise), .shreg(shreg), .codes(codes), .sdout(sdout),
  .proto_err(proto_err)
);

// File: tb/serdac_bank_tb.sv
module serdac_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 0, rst_n = 0, sclk = 0, sdin = 0, sload = 0, preset_n = 1;
  logic sdout, proto_err;
  logic [NCH*8-1:0] codes;

  int checks = 0, errors = 0;
  logic [7:0] model [NCH];
  logic hist[$];
  logic [NCH*8-1:0] exp_q[$];
  string tag_q[$];
  event chk_ev;
  logic [NCH*8-1:0] snap;

  serdac_bank u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin),
    .sload(sload), .preset_n(preset_n), .sdout(sdout), .codes(codes),
    .proto_err(proto_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NCH*8-1:0] packm();
    logic [NCH*8-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input string req);
    logic e;
    sdin = b; waitc(4);
    sclk = 1; waitc(4);
    hist.push_back(b);
    e = (hist.size() >= 12) ? hist[hist.size()-12] : 1'b0;
    check(sdout === e, req, 64'(sdout), 64'(e));
    sclk = 0; waitc(4);
  endtask

  task automatic send_word(input logic [3:0] a, input logic [7:0] d, input string req);
    logic [11:0] w;
    w = {a, d};
    for (int i = 11; i >= 0; i--) shift_bit(w[i], "R6");
    sload = 1; waitc(4); sload = 0; waitc(4);
    if (a >= 1 && a <= NCH) model[a-1] = d;
    exp_q.push_back(packm());
    tag_q.push_back(req);
    ->chk_ev; #2;
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      begin
        logic [NCH*8-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(codes === e, t, codes, e);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < NCH; i++) model[i] = 8'h80;
    waitc(3); rst_n = 1; waitc(3);
    // R1 reset state
    check(codes === {NCH{8'h80}}, "R1", codes, {NCH{8'h80}});
    check(sdout === 1'b0, "R1", 64'(sdout), 0);
    check(proto_err === 1'b0, "R1", 64'(proto_err), 0);
    // R2 R3 R5: every channel, distinct data and bit order
    for (int c = 1; c <= NCH; c++) send_word(4'(c), 8'(8'h11 * c) ^ 8'h35, "R3");
    send_word(4'd3, 8'b1000_0001, "R2");
    send_word(4'd5, 8'h01, "R5");
    // R4 noop addresses
    send_word(4'd0, 8'h3C, "R4");
    send_word(4'd9, 8'hC3, "R4");
    send_word(4'd15, 8'hFF, "R4");
    // R9 idle with sdin toggling
    snap = codes;
    begin
      logic so;
      so = sdout;
      for (int i = 0; i < 10; i++) begin sdin = ~sdin; waitc(3); end
      check(codes === snap, "R9", codes, snap);
      check(sdout === so, "R9", 64'(sdout), 64'(so));
    end
    // R7 preset asynchronous, overriding an active load
    send_word(4'd2, 8'h42, "R5");
    sload = 1; waitc(5);
    #1 preset_n = 0; #1;
    check(codes === {NCH{8'h80}}, "R7", codes, {NCH{8'h80}});
    sload = 0; waitc(5);
    check(codes === {NCH{8'h80}}, "R7", codes, {NCH{8'h80}});
    preset_n = 1; waitc(5);
    for (int i = 0; i < NCH; i++) model[i] = 8'h80;
    check(codes === packm(), "R7", codes, packm());
    // R8 preset released while load still high
    for (int i = 11; i >= 0; i--) shift_bit(i >= 8 ? 1'(4'd3 >> (i-8)) : 1'(8'h5A >> i), "R6");
    preset_n = 0; waitc(2);
    sload = 1; waitc(5);
    check(codes === {NCH{8'h80}}, "R7", codes, {NCH{8'h80}});
    preset_n = 1; waitc(5);
    sload = 0; waitc(4);
    model[2] = 8'h5A;
    check(codes === packm(), "R8", codes, packm());
    // R10 serial clock edge during load, noop word keeps codes
    for (int i = 0; i < 12; i++) shift_bit(1'b0, "R6");
    check(proto_err === 1'b0, "R10", 64'(proto_err), 0);
    sload = 1; waitc(4);
    shift_bit(1'b0, "R10");
    sload = 0; waitc(4);
    check(proto_err === 1'b1, "R10", 64'(proto_err), 1);
    check(codes === packm(), "R10", codes, packm());
    send_word(4'd8, 8'hA7, "R10");
    check(proto_err === 1'b1, "R10", 64'(proto_err), 1);
    waitc(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule